// File: doc/BRIEF.md
# Multichannel Serial Audio Transmitter

This block is the transmit side of a three-wire serial audio link that works as bus master. It drives the bit clock, the word-select line and the serial data line itself. Bit timing comes from a one-cycle `bit_tick` enable in the system clock domain, and every tick marks one half bit period. A frame consists of two system words: the first has word select low and the second has it high. Each system word holds one to four data words, one per channel, so a frame carries up to eight channels.

Samples enter one at a time through a 32-bit port with a ready/valid handshake and wait in a one-entry holding register. Each sample fills exactly one data word. A sample is left-aligned: its most significant bit is bit 31, and only the upper data-word-length bits are sent, MSB first. The rest of each system word is padding, placed either before or after the data, at a selectable level. Other static controls set a one-bit delay between the word-select edge and the first serial bit, and a mute that silences the data bits while the timing keeps running. The configuration is meant to stay constant while the block runs. Change it only while reset is asserted.

Top module: `mc_audio_tx`

## Requirements
- R1: While `rst_n` is low and after it is released with no tick, `sck`, `ws` and `sd` are low, `tx_ready` is high and `underflow` is low.
- R2: Each system word carries `cfg_chan`+1 data words (code 0..3 gives 1..4). Every data word takes a new sample in handshake order, and data words follow each other with no gap.
- R3: A data word is sent from bit 31 of its sample downward, MSB first, for the selected length. The `cfg_dwl` codes 0..6 select 8, 16, 18, 20, 22, 24 and 32 bits.
- R4: A system word lasts `cfg_swl` bit periods. With delay off, `ws` is low for the whole first system word of each frame and high for the whole second.
- R5: With `cfg_delay` = 1, `ws` changes one bit period before the first bit of each system word, so the first serial bit follows the word-select edge by one bit clock.
- R6: With `cfg_pad_first` = 0, the data bits come first and padding fills the tail of the system word. With `cfg_pad_first` = 1, padding comes first and the data sits at the end.
- R7: Padding bits are low when `cfg_pad_high` = 0 and high when it is 1.
- R8: With `cfg_mute` = 1, every data bit is low. Word select, padding and sample consumption are unchanged.
- R9: `sd` and `ws` change only together with a falling edge of `sck`. They are stable at every rising edge, where the receiver samples.
- R10: `cfg_err` is high when the data length code is invalid (7), when `cfg_swl` is outside 8..256, or when channels times data word length exceeds `cfg_swl`. While it is high, `sck`, `ws` and `sd` are held low.
- R11: If the holding register is empty when a data word starts, the previous sample is sent again. `underflow` then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Half-bit-period enable |
| cfg_chan | input | 2 | Data words per system word minus one |
| cfg_dwl | input | 3 | Data word length code |
| cfg_swl | input | 9 | System word length in bits |
| cfg_delay | input | 1 | One-bit delay after the word-select edge |
| cfg_pad_first | input | 1 | Padding placed before the data |
| cfg_pad_high | input | 1 | Padding level |
| cfg_mute | input | 1 | Force data bits low |
| tx_data | input | 32 | Left-aligned sample |
| tx_valid | input | 1 | Sample offered |
| tx_ready | output | 1 | Holding register empty |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| cfg_err | output | 1 | Configuration is invalid |
| underflow | output | 1 | Sticky missing-sample flag |

## Verification
The main path is tried with one, two, three and four channels, and with every data word length. Both delay settings are used, both padding positions and both padding levels, including a case with no padding where the system word is four times the data word. These runs separate a wrong word-select phase from a wrong data offset, and data misplaced at the head of a word from data misplaced at the tail. Random sample values show whether bit order or sample order is wrong. Separate runs cover mute, which must keep consuming samples, a starved input that must repeat the previous sample, and invalid configurations that must keep the bus quiet.

// File: rtl/mc_audio_pkg.sv
package mc_audio_pkg;
  localparam int unsigned SAMPLE_W = 32;
  localparam int unsigned BIDX_W   = $clog2(SAMPLE_W);
  localparam int unsigned LEN_W    = BIDX_W + 1;

  // data word length code -> bits; 0 marks an unusable code
  function automatic logic [LEN_W-1:0] dwl_bits(input logic [2:0] code);
    case (code)
      3'd0:    dwl_bits = LEN_W'(8);
      3'd1:    dwl_bits = LEN_W'(16);
      3'd2:    dwl_bits = LEN_W'(18);
      3'd3:    dwl_bits = LEN_W'(20);
      3'd4:    dwl_bits = LEN_W'(22);
      3'd5:    dwl_bits = LEN_W'(24);
      3'd6:    dwl_bits = LEN_W'(32);
      default: dwl_bits = '0;
    endcase
  endfunction
endpackage

// File: rtl/mc_audio_timing.sv
module mc_audio_timing
  import mc_audio_pkg::*;
#(
  parameter int unsigned SWL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              halt,
  input  logic [SWL_W-1:0]  swl,
  input  logic [SWL_W-1:0]  data_len,
  input  logic [LEN_W-1:0]  dwl,
  input  logic              delay,
  input  logic              pad_first,
  output logic              sck,
  output logic              ws,
  output logic              adv,
  output logic              nxt_data,
  output logic [BIDX_W-1:0] nxt_j,
  output logic              nxt_wstart,
  output logic              cur_data
);
  localparam logic [SWL_W-1:0]  S_ONE = SWL_W'(1);
  localparam logic [LEN_W-1:0]  L_ONE = LEN_W'(1);
  localparam logic [BIDX_W-1:0] J_ONE = BIDX_W'(1);

  logic              sck_q, ws_q, started_q, w_q, data_q;
  logic [SWL_W-1:0]  b_q;
  logic [BIDX_W-1:0] j_q;

  logic [SWL_W-1:0]  pad_len, nb;
  logic              last_b, nw, ws_nxt;

  always_comb begin
    pad_len  = swl - data_len;
    adv      = bit_tick && !halt && (sck_q || !started_q);
    last_b   = (b_q == swl - S_ONE);
    nb       = (!started_q || last_b) ? '0 : b_q + S_ONE;
    nw       = started_q && (last_b ? !w_q : w_q);
    nxt_data = pad_first ? (nb >= pad_len) : (nb < data_len);
    if (nb == '0 || !data_q || ({1'b0, j_q} == dwl - L_ONE))
      nxt_j = '0;
    else
      nxt_j = j_q + J_ONE;
    nxt_wstart = nxt_data && (nxt_j == '0);
    ws_nxt     = (delay && nb == swl - S_ONE) ? !nw : nw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      ws_q      <= 1'b0;
      started_q <= 1'b0;
      w_q       <= 1'b0;
      data_q    <= 1'b0;
      b_q       <= '0;
      j_q       <= '0;
    end else if (halt) begin
      sck_q     <= 1'b0;
      ws_q      <= 1'b0;
      started_q <= 1'b0;
      w_q       <= 1'b0;
      data_q    <= 1'b0;
      b_q       <= '0;
      j_q       <= '0;
    end else if (adv) begin
      sck_q     <= 1'b0;
      started_q <= 1'b1;
      b_q       <= nb;
      w_q       <= nw;
      j_q       <= nxt_j;
      data_q    <= nxt_data;
      ws_q      <= ws_nxt;
    end else if (bit_tick) begin
      sck_q     <= 1'b1;
    end
  end

  assign sck      = sck_q;
  assign ws       = ws_q;
  assign cur_data = data_q;
endmodule

// File: rtl/mc_audio_feed.sv
module mc_audio_feed
  import mc_audio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic                load,
  output logic [SAMPLE_W-1:0] word_sample,
  output logic                underflow
);
  logic [SAMPLE_W-1:0] hold_q, last_q, hold_d, last_d, fresh;
  logic                full_q, under_q, full_d, under_d, accept;

  always_comb begin
    accept      = tx_valid && !full_q;
    fresh       = full_q ? hold_q : last_q;
    word_sample = load ? fresh : last_q;
    full_d      = (full_q && !load) || accept;
    hold_d      = accept ? tx_data : hold_q;
    last_d      = load ? fresh : last_q;
    under_d     = under_q || (load && !full_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      last_q  <= '0;
      full_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      last_q  <= last_d;
      full_q  <= full_d;
      under_q <= under_d;
    end
  end

  assign tx_ready  = !full_q;
  assign underflow = under_q;

  p_hold_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !load) |=> (full_q && $stable(hold_q)));

  p_underflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(under_q) |-> under_q);
endmodule

// File: rtl/mc_audio_tx.sv
module mc_audio_tx
  import mc_audio_pkg::*;
#(
  parameter int unsigned SWL_W   = 9,
  parameter int unsigned MIN_SWL = 8,
  parameter int unsigned MAX_SWL = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic [1:0]       cfg_chan,
  input  logic [2:0]       cfg_dwl,
  input  logic [SWL_W-1:0] cfg_swl,
  input  logic             cfg_delay,
  input  logic             cfg_pad_first,
  input  logic             cfg_pad_high,
  input  logic             cfg_mute,
  input  logic [31:0]      tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             sck,
  output logic             ws,
  output logic             sd,
  output logic             cfg_err,
  output logic             underflow
);
  localparam logic [BIDX_W-1:0] TOP_BIT = BIDX_W'(SAMPLE_W - 1);

  logic [LEN_W-1:0]    dwl_len;
  logic [SWL_W-1:0]    data_len;
  logic                adv, nxt_data, nxt_wstart, cur_data;
  logic [BIDX_W-1:0]   nxt_j;
  logic [SAMPLE_W-1:0] word_sample;
  logic                sd_q, sd_d;

  always_comb begin
    dwl_len  = dwl_bits(cfg_dwl);
    data_len = SWL_W'(dwl_len) * SWL_W'({1'b0, cfg_chan} + 3'd1);
    cfg_err  = (dwl_len == '0) || (cfg_swl < SWL_W'(MIN_SWL)) ||
               (cfg_swl > SWL_W'(MAX_SWL)) || (data_len > cfg_swl);
  end

  mc_audio_timing #(.SWL_W(SWL_W)) timing_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .halt       (cfg_err),
    .swl        (cfg_swl),
    .data_len   (data_len),
    .dwl        (dwl_len),
    .delay      (cfg_delay),
    .pad_first  (cfg_pad_first),
    .sck        (sck),
    .ws         (ws),
    .adv        (adv),
    .nxt_data   (nxt_data),
    .nxt_j      (nxt_j),
    .nxt_wstart (nxt_wstart),
    .cur_data   (cur_data)
  );

  mc_audio_feed feed_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .load        (adv && nxt_wstart),
    .word_sample (word_sample),
    .underflow   (underflow)
  );

  always_comb begin
    if (nxt_data)
      sd_d = !cfg_mute && word_sample[TOP_BIT - nxt_j];
    else
      sd_d = cfg_pad_high;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sd_q <= 1'b0;
    else if (cfg_err) sd_q <= 1'b0;
    else if (adv)     sd_q <= sd_d;
  end

  assign sd = sd_q;

  p_sd_stable_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> ($stable(sd) && $stable(ws)));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> (!sck && !ws && !sd));

  p_mute_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mute && !cfg_err && cur_data) |-> !sd);
endmodule

// File: tb/mc_audio_tx_tb_top.sv
module mc_audio_tx_tb_top;
  logic        clk, rst_n, bit_tick, tick_en;
  logic [1:0]  cfg_chan;
  logic [2:0]  cfg_dwl;
  logic [8:0]  cfg_swl;
  logic        cfg_delay, cfg_pad_first, cfg_pad_high, cfg_mute;
  logic [31:0] tx_data;
  logic        tx_valid;
  logic        tx_ready, sck, ws, sd, cfg_err, underflow;

  int n_chk, n_fail;
  logic [31:0] exp_q[$];

  mc_audio_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .cfg_chan(cfg_chan), .cfg_dwl(cfg_dwl), .cfg_swl(cfg_swl),
    .cfg_delay(cfg_delay), .cfg_pad_first(cfg_pad_first),
    .cfg_pad_high(cfg_pad_high), .cfg_mute(cfg_mute),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .sck(sck), .ws(ws), .sd(sd), .cfg_err(cfg_err), .underflow(underflow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) bit_tick <= tick_en && !bit_tick;

  function automatic int dwl_of(input logic [2:0] c);
    case (c)
      3'd0: return 8;   3'd1: return 16;  3'd2: return 18;
      3'd3: return 20;  3'd4: return 22;  3'd5: return 24;
      3'd6: return 32;  default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    tick_en  = 1'b0;
    tx_valid = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] s);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = s;
    while (!tx_ready) @(negedge clk);
    exp_q.push_back(s);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drive(input int n);
    for (int i = 0; i < n; i++) push($urandom);
  endtask

  task automatic monitor(input int nslots);
    int swl, dwl, dlen, pad, n, b, d, j, ws_err, pad_err, edge_err;
    logic [31:0] cur, last, acc, mask, expw;
    logic prev, sd_lo, ws_lo, isdata, exp_ws;
    swl  = int'(cfg_swl);
    dwl  = dwl_of(cfg_dwl);
    dlen = dwl * (int'(cfg_chan) + 1);
    pad  = swl - dlen;
    mask = 32'hFFFF_FFFF << (32 - dwl);
    n = 0; ws_err = 0; pad_err = 0; edge_err = 0;
    prev = sck; sd_lo = sd; ws_lo = ws;
    cur = '0; last = '0; acc = '0;
    while (n < nslots) begin
      @(negedge clk);
      if (sck && !prev) begin
        if (sd !== sd_lo || ws !== ws_lo) edge_err++;
        b = n % swl;
        exp_ws = cfg_delay ? (((n + 1) / swl) % 2 == 1) : ((n / swl) % 2 == 1);
        if (ws !== exp_ws) ws_err++;
        isdata = cfg_pad_first ? (b >= pad) : (b < dlen);
        if (isdata) begin
          d = cfg_pad_first ? b - pad : b;
          j = d % dwl;
          if (j == 0) begin
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            else cur = last;
            last = cur;
            acc  = '0;
          end
          acc[31 - j] = sd;
          if (j == dwl - 1) begin
            expw = cfg_mute ? 32'h0 : (cur & mask);
            if (cfg_mute) chk(acc == expw, "R8 muted data word", acc, expw);
            else chk(acc == expw, "R2 R3 data word", acc, expw);
          end
        end else if (sd !== cfg_pad_high) pad_err++;
        if (b == swl - 1) begin
          chk(pad_err == 0, "R6 R7 padding bits", pad_err, 0);
          if (cfg_delay) chk(ws_err == 0, "R5 delayed word select", ws_err, 0);
          else chk(ws_err == 0, "R4 word select phase", ws_err, 0);
          pad_err = 0; ws_err = 0;
        end
        n++;
      end
      if (!sck) begin sd_lo = sd; ws_lo = ws; end
      prev = sck;
    end
    chk(edge_err == 0, "R9 data stable at rising sck", edge_err, 0);
  endtask

  task automatic run_cfg(input int chan, input int dcode, input int swl,
                         input bit dly, input bit padf, input bit padh,
                         input bit mute, input int frames, input bit starve);
    int words;
    cfg_chan = 2'(chan); cfg_dwl = 3'(dcode); cfg_swl = 9'(swl);
    cfg_delay = dly; cfg_pad_first = padf; cfg_pad_high = padh; cfg_mute = mute;
    do_reset();
    exp_q.delete();
    words = frames * 2 * (chan + 1);
    push($urandom);
    repeat (3) @(negedge clk);
    tick_en = 1'b1;
    fork
      if (!starve) drive(words - 1);
      monitor(frames * 2 * swl);
    join
    tick_en = 1'b0;
    chk(underflow == starve, "R11 underflow flag", underflow, starve);
    chk(exp_q.size() == 0, "R2 all samples consumed", exp_q.size(), 0);
  endtask

  task automatic run_err(input int chan, input int dcode, input int swl);
    int highs;
    cfg_chan = 2'(chan); cfg_dwl = 3'(dcode); cfg_swl = 9'(swl);
    cfg_delay = 1'b1; cfg_pad_first = 1'b0; cfg_pad_high = 1'b1; cfg_mute = 1'b0;
    do_reset();
    tick_en = 1'b1;
    highs = 0;
    repeat (60) begin
      @(negedge clk);
      if (sck || ws || sd) highs++;
    end
    tick_en = 1'b0;
    chk(cfg_err == 1'b1, "R10 error flagged", cfg_err, 1);
    chk(highs == 0, "R10 bus held low", highs, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    bit_tick = 1'b0; tick_en = 1'b0; tx_valid = 1'b0; tx_data = '0;
    cfg_chan = 2'd0; cfg_dwl = 3'd1; cfg_swl = 9'd32;
    cfg_delay = 1'b0; cfg_pad_first = 1'b0; cfg_pad_high = 1'b0; cfg_mute = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({sck, ws, sd} == 3'b000, "R1 bus low in reset", {sck, ws, sd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({sck, ws, sd, underflow} == 4'b0000, "R1 idle after reset",
        {sck, ws, sd, underflow}, 0);
    chk(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
    chk(cfg_err == 1'b0, "R10 valid config", cfg_err, 0);

    //      ch code swl dly padf padh mute frm starve
    run_cfg(0, 1,  32, 0,  0,   0,   0,   2,  0);
    run_cfg(3, 1,  64, 1,  0,   0,   0,   2,  0);
    run_cfg(1, 5,  64, 0,  1,   1,   0,   2,  0);
    run_cfg(2, 3,  64, 1,  0,   1,   0,   2,  0);
    run_cfg(1, 0,  32, 1,  1,   0,   0,   2,  0);
    run_cfg(0, 6,  32, 0,  0,   1,   0,   2,  0);
    run_cfg(3, 2,  80, 0,  1,   0,   0,   2,  0);
    run_cfg(1, 4,  48, 1,  1,   1,   0,   2,  0);
    run_cfg(3, 6, 256, 0,  1,   1,   0,   1,  0);
    run_cfg(1, 1,  40, 1,  0,   1,   1,   2,  0);
    run_cfg(0, 1,  32, 0,  0,   0,   0,   1,  1);

    run_err(3, 6, 64);
    run_err(0, 1, 300);
    run_err(0, 7, 64);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule